// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial-management front end of a clock generator. A host controller reads and writes a small bank of 8-bit configuration registers over a two-wire SMBus link. A fast system clock samples the SCL and SDA pins through two-flop synchronizers. Edge detectors recognise start, repeated start and stop conditions. A single state machine then walks through the address, command, count and data phases of each transaction and controls an open-drain SDA pull-down.

The top bit of the command byte picks the access style. When it is 1, the transfer touches one register, and the low seven bits give that register's index. When it is 0, the transfer is a block transfer that starts at register 0 and walks upward. In a block write, the host sends a byte count before the data. In a block read, the slave returns the byte count first. Every accepted write shows up on a one-cycle write port, and the whole register bank is also presented as a flat vector.

The state machine uses these states: IDLE, ADDR, ADDR_ACK, CMD, CMD_ACK, COUNT, COUNT_ACK, WDATA, WDATA_ACK, TX, TX_ACK and DROP.
- A stop moves any state to IDLE. A start or repeated start moves any state to ADDR.
- ADDR goes to ADDR_ACK when the address matches, and to DROP otherwise.
- ADDR_ACK goes to TX for a read and to CMD for a write.
- CMD goes to CMD_ACK for a legal command, and to DROP otherwise.
- CMD_ACK goes to COUNT for a block command and to WDATA for an indexed command.
- COUNT goes to COUNT_ACK, and COUNT_ACK goes to WDATA.
- WDATA goes to WDATA_ACK when the index is in range, and to DROP otherwise. WDATA_ACK returns to WDATA.
- TX goes to TX_ACK. TX_ACK returns to TX when the host acknowledges, and goes to DROP when it does not.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1101001, so the write address byte is D2h and the read address byte is D3h. After any other address it leaves SDA released for the rest of the transaction, and no register changes.
- R2: Command bit 7 = 1 selects indexed access, with bits 6:0 as the register index. A data byte written after such a command is stored in that register and acknowledged.
- R3: An indexed command followed by a repeated start and the read address returns the addressed register, most significant bit first.
- R4: An index at or above NREG (16 by default) is not acknowledged and causes no write. A block write byte that would land past the last register is not acknowledged either.
- R5: Block write is command 00h, then a count byte, then data bytes. The data bytes are stored in registers 0, 1, 2 and so on. Every byte is acknowledged.
- R6: Block read is command 00h, then a repeated start with the read address. The slave returns NREG as the first byte, then the registers from 0 upward.
- R7: A read ends when the host does not acknowledge a byte, and the slave then releases SDA. A stop returns the slave to IDLE from any state, including the middle of a byte, and leaves unfinished bytes unwritten. A write may end after any complete byte.
- R8: At reset, every register is 00h except register 15, which is 03h. SDA is released and the write port is idle.
- R9: A block command with any of bits 6:0 set is not acknowledged.
- R10: Each accepted data byte gives exactly one single-cycle pulse on wr_stb, with the index on wr_idx and the byte on wr_dat.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level (wired-AND of host and slave) |
| sda_oe | output | 1 | 1 = pull SDA low |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_idx | output | 7 | Index of the stored byte |
| wr_dat | output | 8 | Value of the stored byte |
| cfg_regs | output | NREG*8 | Register bank, register k at bits 8k+7:8k |

## Verification
Two events can fall in the same cycle. A stop or repeated start can be detected on the very SDA edge that the bit shifter is also watching. Separately, the write commit for a data byte happens on the same SCL fall that hands the bus to the acknowledge phase. The bench aborts an indexed write with a stop after only four data bits, then checks through cfg_regs and the write-pulse count that nothing was stored. It then runs a normal read to show that the slave recovered. Block writes that overrun the last register and writes stopped after a few bytes check that the commit and the acknowledge always agree.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W   = 8;
    localparam int CMD_IDXW = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_DROP
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_lvl;
            sda_q  <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
    parameter int            NREG    = 16,
    parameter int            W       = 8,
    parameter int            IDXW    = 7,
    parameter int            DEF_IDX = 15,
    parameter logic [W-1:0]  DEF_VAL = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDXW-1:0]   widx,
    input  logic [W-1:0]      wdat,
    input  logic [IDXW-1:0]   ridx,
    output logic [W-1:0]      rdat,
    output logic [NREG*W-1:0] flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [W-1:0] RV = (g == DEF_IDX) ? DEF_VAL : '0;
        logic [W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= RV;
            else if (we && widx == IDXW'(g))       q <= wdat;
        end

        assign flat[g*W +: W] = q;

        AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == IDXW'(g)) |=> (q == $past(wdat))); // R2
    end

    always_comb begin
        rdat = '1;
        for (int k = 0; k < NREG; k++)
            if (ridx == IDXW'(k)) rdat = flat[k*W +: W];
    end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
    import smb_pkg::*;
#(
    parameter int                  NREG     = 16,
    parameter logic [6:0]          DEV_ADDR = 7'b1101001,
    parameter int                  DEF_IDX  = 15,
    parameter logic [BYTE_W-1:0]   DEF_VAL  = 8'h03
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_in,
    input  logic                    sda_in,
    output logic                    sda_oe,
    output logic                    wr_stb,
    output logic [CMD_IDXW-1:0]     wr_idx,
    output logic [BYTE_W-1:0]       wr_dat,
    output logic [NREG*BYTE_W-1:0]  cfg_regs
);
    localparam logic [CMD_IDXW-1:0] LAST_IDX = CMD_IDXW'(NREG - 1);
    localparam logic [BYTE_W-1:0]   CNT_BYTE = BYTE_W'(NREG);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smb_cfg_bank #(
        .NREG(NREG), .W(BYTE_W), .IDXW(CMD_IDXW),
        .DEF_IDX(DEF_IDX), .DEF_VAL(DEF_VAL)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_stb), .widx(wr_idx), .wdat(wr_dat),
        .ridx(ptr), .rdat(rd_byte), .flat(cfg_regs)
    );

    smb_state_e          state;
    logic [3:0]          bitcnt;
    logic [BYTE_W-1:0]   rx_sh, tx_sh, rd_byte;
    logic [CMD_IDXW-1:0] ptr;
    logic                blk, is_rd, send_cnt;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            ptr      <= '0;
            blk      <= 1'b0;
            is_rd    <= 1'b0;
            send_cnt <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_dat   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_det) begin
                state <= ST_IDLE;
            end else if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
            end else begin
                if (scl_rise) begin
                    rx_sh  <= {rx_sh[BYTE_W-2:0], sda_lvl};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_IDLE, ST_DROP: ;
                        ST_ADDR: if (bitcnt == 4'd8) begin
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                state <= ST_ADDR_ACK;
                                is_rd <= rx_sh[0];
                            end else state <= ST_DROP;
                        end
                        ST_ADDR_ACK: begin
                            bitcnt <= '0;
                            if (is_rd) begin
                                state <= ST_TX;
                                if (send_cnt) begin
                                    tx_sh    <= CNT_BYTE;
                                    send_cnt <= 1'b0;
                                end else begin
                                    tx_sh <= rd_byte;
                                    if (ptr <= LAST_IDX) ptr <= ptr + 1'b1;
                                end
                            end else state <= ST_CMD;
                        end
                        ST_CMD: if (bitcnt == 4'd8) begin
                            if (rx_sh[7] && rx_sh[6:0] <= LAST_IDX) begin
                                state <= ST_CMD_ACK;
                                blk   <= 1'b0;
                                ptr   <= rx_sh[6:0];
                            end else if (!rx_sh[7] && rx_sh[6:0] == '0) begin
                                state <= ST_CMD_ACK;
                                blk   <= 1'b1;
                                ptr   <= '0;
                            end else state <= ST_DROP;
                        end
                        ST_CMD_ACK: begin
                            bitcnt   <= '0;
                            send_cnt <= blk;
                            state    <= blk ? ST_COUNT : ST_WDATA;
                        end
                        ST_COUNT: if (bitcnt == 4'd8) state <= ST_COUNT_ACK;
                        ST_COUNT_ACK: begin
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                        ST_WDATA: if (bitcnt == 4'd8) begin
                            if (ptr <= LAST_IDX) begin
                                wr_stb <= 1'b1;
                                wr_idx <= ptr;
                                wr_dat <= rx_sh;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_WDATA_ACK;
                            end else state <= ST_DROP;
                        end
                        ST_WDATA_ACK: begin
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                        ST_TX: begin
                            if (bitcnt == 4'd8) state <= ST_TX_ACK;
                            else tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                        end
                        ST_TX_ACK: begin
                            if (!rx_sh[0]) begin
                                bitcnt <= '0;
                                state  <= ST_TX;
                                if (send_cnt) begin
                                    tx_sh    <= CNT_BYTE;
                                    send_cnt <= 1'b0;
                                end else begin
                                    tx_sh <= rd_byte;
                                    if (ptr <= LAST_IDX) ptr <= ptr + 1'b1;
                                end
                            end else state <= ST_DROP;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX:                                               sda_oe = ~tx_sh[7];
            default:                                             sda_oe = 1'b0;
        endcase
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)); // R7
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx <= LAST_IDX)); // R4
    AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_WDATA_ACK && sda_oe)); // R10
    AST_BAD_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && !start_det && !stop_det && bitcnt == 4'd8
         && rx_sh[7:1] != DEV_ADDR) |=> (state == ST_DROP && !sda_oe)); // R1
    AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe)); // R11
endmodule

// File: tb/cfg_smbus_slave_tb.sv
module cfg_smbus_slave_tb;
    localparam int NREG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_line;
    logic sda_oe, wr_stb;
    logic [6:0] wr_idx;
    logic [7:0] wr_dat;
    logic [NREG*8-1:0] cfg_regs;

    assign sda_line = sda_m & ~sda_oe;
    always #2.5 clk = ~clk;

    cfg_smbus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_dat(wr_dat),
        .cfg_regs(cfg_regs)
    );

    int n_chk = 0, n_fail = 0, wr_cnt = 0;
    logic [6:0] wr_last_idx;
    logic [7:0] wr_last_dat;
    logic [7:0] exp_r [NREG];

    always @(posedge clk) if (rst_n && wr_stb) begin
        wr_cnt++;
        wr_last_idx = wr_idx;
        wr_last_dat = wr_dat;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wc(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wc(20); sda_m = 0; wc(20); scl_m = 0;
    endtask
    task automatic bus_rstart();
        wc(10); sda_m = 1; wc(10); scl_m = 1; wc(20); sda_m = 0; wc(20); scl_m = 0;
    endtask
    task automatic bus_stop();
        wc(10); sda_m = 0; wc(10); scl_m = 1; wc(20); sda_m = 1; wc(20);
    endtask
    task automatic put_bit(input logic b);
        wc(10); sda_m = b; wc(10); scl_m = 1; wc(20); scl_m = 0;
    endtask
    task automatic get_bit(output logic b);
        wc(5); sda_m = 1; wc(15); scl_m = 1; wc(10); b = sda_line; wc(10); scl_m = 0;
    endtask
    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        ack = ~a;
    endtask
    task automatic get_byte(input logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(last);
    endtask

    task automatic byte_write(input int idx, input logic [7:0] d);
        logic a;
        int c0;
        c0 = wr_cnt;
        bus_start();
        put_byte(8'hD2, a); chk("R1 addr ack", a, 1);
        put_byte(8'h80 | 8'(idx), a); chk("R2 cmd ack", a, 1);
        put_byte(d, a); chk("R2 data ack", a, 1);
        bus_stop();
        wc(4);
        chk("R2 stored", cfg_regs[idx*8 +: 8], d);
        chk("R10 one pulse", wr_cnt - c0, 1);
        chk("R10 wr_idx", wr_last_idx, idx);
        chk("R10 wr_dat", wr_last_dat, d);
        exp_r[idx] = d;
    endtask

    task automatic byte_read(input int idx);
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(8'hD2, a); chk("R3 addr ack", a, 1);
        put_byte(8'h80 | 8'(idx), a); chk("R3 cmd ack", a, 1);
        bus_rstart();
        put_byte(8'hD3, a); chk("R3 read addr ack", a, 1);
        get_byte(1'b1, d);
        chk("R3 read data", d, exp_r[idx]);
        wc(8);
        chk("R7 released after nack", sda_line, 1);
        bus_stop();
    endtask

    task automatic block_read(input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(8'hD2, a); chk("R6 addr ack", a, 1);
        put_byte(8'h00, a); chk("R6 cmd ack", a, 1);
        bus_rstart();
        put_byte(8'hD3, a); chk("R6 read addr ack", a, 1);
        get_byte(1'b0, d); chk("R6 byte count", d, NREG);
        for (int i = 0; i < n; i++) begin
            get_byte(i == n - 1, d);
            chk("R6 block data", d, exp_r[i]);
        end
        bus_stop();
        wc(4);
        chk("R7 idle after stop", sda_oe, 0);
    endtask

    task automatic block_write(input int n, input int salt);
        logic a;
        logic [7:0] d;
        int c0;
        c0 = wr_cnt;
        bus_start();
        put_byte(8'hD2, a); chk("R5 addr ack", a, 1);
        put_byte(8'h00, a); chk("R5 cmd ack", a, 1);
        put_byte(8'(n), a); chk("R5 count ack", a, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'(i * 11 + salt) ^ 8'h5C;
            put_byte(d, a);
            chk("R5 data ack", a, (i < NREG) ? 1 : 0);
            if (i < NREG) exp_r[i] = d;
        end
        bus_stop();
        wc(4);
        chk("R10 block pulses", wr_cnt - c0, (n < NREG) ? n : NREG);
        for (int i = 0; i < NREG; i++) chk("R5 bank contents", cfg_regs[i*8 +: 8], exp_r[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] ad;
        int c0;
        for (int i = 0; i < NREG; i++) exp_r[i] = (i == 15) ? 8'h03 : 8'h00;
        wc(5);
        rst_n = 1;
        wc(5);
        // R8 reset state
        chk("R8 sda released", sda_oe, 0);
        chk("R8 no write", wr_stb, 0);
        for (int i = 0; i < NREG; i++) chk("R8 default", cfg_regs[i*8 +: 8], exp_r[i]);
        block_read(NREG);

        // R2/R3 sweep every index
        for (int i = 0; i < NREG; i++) byte_write(i, 8'(i * 37 + 5));
        for (int i = 0; i < NREG; i++) byte_read(i);

        // R5/R6 full block, overrun, partial
        block_write(NREG, 3);
        block_read(NREG);
        block_write(NREG + 1, 90);
        block_write(3, 200);
        block_read(5);

        // R1 wrong addresses: single-bit flips and extremes
        for (int k = 0; k < 9; k++) begin
            ad = (k < 7) ? (8'hD2 ^ (8'h02 << k)) : ((k == 7) ? 8'h00 : 8'hFE);
            for (int rw = 0; rw < 2; rw++) begin
                c0 = wr_cnt;
                bus_start();
                put_byte(ad | 8'(rw), a); chk("R1 foreign addr nack", a, 0);
                put_byte(8'h82, a);       chk("R1 cmd ignored", a, 0);
                put_byte(8'hEE, a);       chk("R1 data ignored", a, 0);
                bus_stop();
                wc(4);
                chk("R1 no write", wr_cnt - c0, 0);
                chk("R1 reg kept", cfg_regs[2*8 +: 8], exp_r[2]);
            end
        end

        // R4 out-of-range index
        for (int i = NREG; i < NREG + 3; i++) begin
            c0 = wr_cnt;
            bus_start();
            put_byte(8'hD2, a);          chk("R4 addr ack", a, 1);
            put_byte(8'h80 | 8'(i), a);  chk("R4 index nack", a, 0);
            put_byte(8'h11, a);          chk("R4 data nack", a, 0);
            bus_stop();
            wc(4);
            chk("R4 no write", wr_cnt - c0, 0);
        end
        bus_start();
        put_byte(8'hD2, a); put_byte(8'hFF, a); chk("R4 top index nack", a, 0);
        bus_stop();

        // R9 block command with nonzero low bits
        for (int k = 0; k < 7; k++) begin
            bus_start();
            put_byte(8'hD2, a);           chk("R9 addr ack", a, 1);
            put_byte(8'h01 << k, a);      chk("R9 bad block cmd nack", a, 0);
            bus_stop();
        end

        // R7 stop in the middle of a data byte
        c0 = wr_cnt;
        bus_start();
        put_byte(8'hD2, a); chk("R7 addr ack", a, 1);
        put_byte(8'h83, a); chk("R7 cmd ack", a, 1);
        for (int i = 7; i >= 4; i--) put_bit(ad[i] ^ 1'b1);
        bus_stop();
        wc(4);
        chk("R7 abort no write", wr_cnt - c0, 0);
        chk("R7 abort reg kept", cfg_regs[3*8 +: 8], exp_r[3]);
        chk("R7 idle after abort", sda_oe, 0);
        byte_read(3);

        // R11 slave drive observed only in low phase: final read with MSB pattern
        byte_write(9, 8'hA5);
        byte_read(9);

        finish_run();
    end
endmodule